// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a host a byte-wide way into a bank of 256 configuration registers through a decode range only two bytes wide. The host first writes a register number to the low byte of the range, the selector. It then reads or writes the chosen register through the high byte, the data byte. Some registers take writes. Every other index is protected: a write to it is dropped, and it always reads as zero. The writable registers come up with fixed power-on values.

A parent bridge provides one enable bit, `cfg_win_en`. The window answers the bus only while that bit is set. The block samples the bit into a flop, and that flop clears on reset. Two of the registers hold the base addresses of two serial ports. The serial ports expect these bases never to move. A write that tries to move either base is still stored, and it also sets a sticky error flag that a separate input clears.

The bus is a simple synchronous I/O port. It carries one address bit, a write strobe, a read strobe and byte-wide data in each direction. Only single-byte accesses exist. Reads return data combinationally in the cycle of the read strobe. Writes take effect at the next rising clock edge.

Top module: `cfgwin_port`

## Requirements
- R1: A claimed write with `io_addr`=0 loads the selector from `io_wdata`. A claimed read with `io_addr`=0 returns the selector, which is 0x00 after reset.
- R2: A claimed read with `io_addr`=1 returns, in the same cycle, the register that the current selector picks.
- R3: Only these indices take a claimed data write: 0xE0, 0xE1, 0xE2, 0xE3, 0xE6, 0xE7, 0xE8, 0xEE, 0xEF, 0xF0, 0xF1, 0xF2, 0xF4, 0xF6, 0xF8 and 0xFC. A write to one of them is visible from the next clock edge. A data write to any other index is dropped, and that index always reads 0x00.
- R4: After reset the registers read as follows: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE. Every other index reads 0x00.
- R5: The window opens one clock edge after `cfg_win_en` is seen high, and it is closed after reset. While it is closed, `io_claim` stays low, `io_rdata` is 0x00, and writes change neither the selector nor any register.
- R6: A claimed data write to 0xE7 with a value other than 0xFE, or to 0xE8 with a value other than 0xBE, still stores the value and sets `reloc_err` at the next edge. A write of 0xFE to 0xE7 or of 0xBE to 0xE8 leaves the flag as it was.
- R7: `reloc_err` stays set until `reloc_err_clr` is high at a clock edge. If a new relocation write arrives at the same edge as the clear, the flag stays set.
- R8: `io_rdata` is 0x00 whenever no claimed read is in progress.
- R9: `io_claim` is high exactly when the window is open and `io_rd` or `io_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win_en | input | 1 | Window enable bit from the parent bridge's configuration space |
| io_addr | input | 1 | Byte select in the range: 0 = selector, 1 = data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when the block does not drive it |
| io_claim | output | 1 | The block decodes the current access |
| reloc_err_clr | input | 1 | Clears the relocation flag |
| reloc_err | output | 1 | Sticky flag: a serial port base was moved |

## Verification
Results arrive at three different points in time. Read data and the claim are combinational and appear in the same cycle as the strobe. Selector, register and flag updates appear after the first rising edge that follows the write. A change of the enable bit takes effect after one edge. The bench changes inputs on the falling edge, samples outputs 1 ns later, and lifts the read strobe before the next rising edge. Every expected value is therefore read back one half-cycle after the edge that should have produced it. The enable latency is checked on both sides of its edge.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int CFG_DW = 8;
    localparam int CFG_IW = 8;
    localparam int CFG_NREG = 1 << CFG_IW;

    typedef logic [CFG_DW-1:0] cfg_byte_t;
    typedef logic [CFG_IW-1:0] cfg_idx_t;

    // decoded bus request after window gating
    typedef struct packed {
        logic      wr_sel;
        logic      wr_dat;
        logic      rd_any;
        cfg_byte_t wdata;
    } cfg_req_t;

    localparam cfg_idx_t SER0_IDX  = 8'hE7;
    localparam cfg_idx_t SER1_IDX  = 8'hE8;
    localparam cfg_byte_t SER0_FIX = 8'hFE;
    localparam cfg_byte_t SER1_FIX = 8'hBE;

    function automatic logic idx_writable(input cfg_idx_t i);
        logic prot;
        prot = (i <= 8'hDF) || (i == 8'hE4) || (i == 8'hE5)
            || (i >= 8'hE9 && i <= 8'hED)
            || (i == 8'hF3) || (i == 8'hF5) || (i == 8'hF7)
            || (i >= 8'hF9 && i <= 8'hFB)
            || (i >= 8'hFD);
        return !prot;
    endfunction

    function automatic cfg_byte_t idx_default(input cfg_idx_t i);
        case (i)
            8'hE0:   return 8'h3C;
            8'hE2:   return 8'h03;
            8'hE3:   return 8'hFC;
            8'hE6:   return 8'hDE;
            8'hE7:   return 8'hFE;
            8'hE8:   return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_relocation(input cfg_idx_t i, input cfg_byte_t d);
        return ((i == SER0_IDX) && (d != SER0_FIX))
            || ((i == SER1_IDX) && (d != SER1_FIX));
    endfunction

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
    import cfgwin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      win_en,
    input  logic      addr,
    input  logic      wr,
    input  logic      rd,
    input  cfg_byte_t wdata,
    output logic      claim,
    output cfg_req_t  req
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= win_en;
    end

    always_comb begin
        claim      = open_q && (wr || rd);
        req.wr_sel = open_q && wr && !addr;
        req.wr_dat = open_q && wr && addr;
        req.rd_any = open_q && rd;
        req.wdata  = wdata;
    end
endmodule

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
    import cfgwin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cfg_req_t  req,
    output cfg_idx_t  idx,
    output cfg_byte_t rd_data
);
    cfg_idx_t  idx_q;
    cfg_byte_t regs [CFG_NREG];

    always_ff @(posedge clk) begin
        if (rst)             idx_q <= '0;
        else if (req.wr_sel) idx_q <= req.wdata;
    end

    for (genvar g = 0; g < CFG_NREG; g++) begin : g_reg
        if (idx_writable(cfg_idx_t'(g))) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= idx_default(cfg_idx_t'(g));
                else if (req.wr_dat && idx_q == cfg_idx_t'(g))
                    regs[g] <= req.wdata;
            end
        end else begin : g_ro
            assign regs[g] = idx_default(cfg_idx_t'(g));
        end
    end

    assign idx     = idx_q;
    assign rd_data = regs[idx_q];
endmodule

// File: rtl/cfgwin_reloc_mon.sv
module cfgwin_reloc_mon
    import cfgwin_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cfg_req_t req,
    input  cfg_idx_t idx,
    input  logic     clr,
    output logic     flag
);
    logic hit;
    logic flag_q;

    assign hit = req.wr_dat && is_relocation(idx, req.wdata);

    always_ff @(posedge clk) begin
        if (rst)       flag_q <= 1'b0;
        else if (hit)  flag_q <= 1'b1;
        else if (clr)  flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/cfgwin_port.sv
module cfgwin_port
    import cfgwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_win_en,
    input  logic       io_addr,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic       io_claim,
    input  logic       reloc_err_clr,
    output logic       reloc_err
);
    cfg_req_t  req;
    cfg_idx_t  idx_q;
    cfg_byte_t reg_rd;

    cfgwin_decode u_dec (
        .clk(clk), .rst(rst), .win_en(cfg_win_en), .addr(io_addr),
        .wr(io_wr), .rd(io_rd), .wdata(io_wdata), .claim(io_claim), .req(req)
    );

    cfgwin_regfile u_rf (
        .clk(clk), .rst(rst), .req(req), .idx(idx_q), .rd_data(reg_rd)
    );

    cfgwin_reloc_mon u_mon (
        .clk(clk), .rst(rst), .req(req), .idx(idx_q),
        .clr(reloc_err_clr), .flag(reloc_err)
    );

    always_comb begin
        if (!req.rd_any) io_rdata = '0;
        else if (io_addr) io_rdata = reg_rd;
        else io_rdata = idx_q;
    end
endmodule

// File: rtl/cfgwin_port_chk.sv
module cfgwin_port_chk
    import cfgwin_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cfg_win_en,
    input logic       io_addr,
    input logic       io_wr,
    input logic       io_rd,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic       io_claim,
    input logic       reloc_err_clr,
    input logic       reloc_err,
    input logic [7:0] idx
);
    p_claim_needs_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        io_claim |-> (io_rd || io_wr));

    p_closed_no_claim_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_win_en) || $past(rst)) |-> !io_claim);

    p_idle_rdata_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !(io_claim && io_rd) |-> (io_rdata == 8'h00));

    p_sel_load_r1: assert property (@(posedge clk) disable iff (rst)
        (io_claim && io_wr && !io_addr) |=> (idx == $past(io_wdata)));

    p_reloc_set_r6: assert property (@(posedge clk) disable iff (rst)
        (io_claim && io_wr && io_addr && is_relocation(idx, io_wdata)) |=> reloc_err);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (reloc_err && !reloc_err_clr) |=> reloc_err);
endmodule

bind cfgwin_port cfgwin_port_chk chk_i (
    .clk(clk), .rst(rst), .cfg_win_en(cfg_win_en), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_claim(io_claim), .reloc_err_clr(reloc_err_clr), .reloc_err(reloc_err),
    .idx(idx_q)
);

// File: tb/cfgwin_port_tb.sv
`timescale 1ns/1ps
module cfgwin_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_win_en = 1'b0;
    logic       io_addr = 1'b0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       io_claim;
    logic       reloc_err_clr = 1'b0;
    logic       reloc_err;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cfgwin_port dut_i (
        .clk(clk), .rst(rst), .cfg_win_en(cfg_win_en), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_claim(io_claim), .reloc_err_clr(reloc_err_clr), .reloc_err(reloc_err)
    );

    function automatic bit tb_writable(input int i);
        int list [16] = '{'hE0, 'hE1, 'hE2, 'hE3, 'hE6, 'hE7, 'hE8, 'hEE,
                          'hEF, 'hF0, 'hF1, 'hF2, 'hF4, 'hF6, 'hF8, 'hFC};
        foreach (list[k]) if (list[k] == i) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] tb_default(input int i);
        case (i)
            'hE0: return 8'h3C;  'hE2: return 8'h03;  'hE3: return 8'hFC;
            'hE6: return 8'hDE;  'hE7: return 8'hFE;  'hE8: return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] v, output logic c);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        v = io_rdata; c = io_claim;
        io_rd = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] i, output logic [7:0] v);
        logic c;
        bus_wr(1'b0, i);
        bus_rd(1'b1, v, c);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 00 expected 01");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic c;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5: closed after reset even with strobes
        bus_rd(1'b1, v, c);
        chk("R5 claim closed after reset", {7'd0, c}, 8'h00);
        chk("R5 rdata closed after reset", v, 8'h00);
        chk("R7 flag after reset", {7'd0, reloc_err}, 8'h00);

        // R5 latency: enable seen at negedge, not yet open before edge
        @(negedge clk);
        cfg_win_en = 1'b1; io_rd = 1'b1; io_addr = 1'b0;
        #1;
        chk("R5 open latency before edge", {7'd0, io_claim}, 8'h00);
        @(negedge clk);
        #1;
        chk("R9 claim after edge", {7'd0, io_claim}, 8'h01);
        chk("R1 selector after reset", io_rdata, 8'h00);
        io_rd = 1'b0;
        #1;
        chk("R9 no strobe no claim", {7'd0, io_claim}, 8'h00);
        chk("R8 idle rdata", io_rdata, 8'h00);

        // R4 / R2: reset defaults across all indices
        for (int i = 0; i < 256; i++) begin
            read_reg(8'(i), v);
            chk($sformatf("R4 default idx %02h", i), v, tb_default(i));
        end

        // R1: selector readback
        bus_wr(1'b0, 8'hA7);
        bus_rd(1'b0, v, c);
        chk("R1 selector readback", v, 8'hA7);

        // R3: write sweep with a pattern, then readback sweep
        for (int i = 0; i < 256; i++) begin
            bus_wr(1'b0, 8'(i));
            bus_wr(1'b1, 8'(i) ^ 8'h5A);
        end
        for (int i = 0; i < 256; i++) begin
            read_reg(8'(i), v);
            chk($sformatf("R3 sweep idx %02h", i), v,
                tb_writable(i) ? (8'(i) ^ 8'h5A) : 8'h00);
        end
        // E7 got BD and E8 got B2: relocation
        chk("R6 flag after sweep", {7'd0, reloc_err}, 8'h01);

        // R7 clear
        @(negedge clk); reloc_err_clr = 1'b1;
        @(negedge clk); reloc_err_clr = 1'b0;
        chk("R7 cleared", {7'd0, reloc_err}, 8'h00);

        // R6 fixed values leave the flag clear
        bus_wr(1'b0, 8'hE7); bus_wr(1'b1, 8'hFE);
        bus_wr(1'b0, 8'hE8); bus_wr(1'b1, 8'hBE);
        chk("R6 fixed values no flag", {7'd0, reloc_err}, 8'h00);
        bus_wr(1'b1, 8'h00);
        chk("R6 E8 moved sets flag", {7'd0, reloc_err}, 8'h01);
        read_reg(8'hE8, v);
        chk("R6 E8 moved value stored", v, 8'h00);
        repeat (3) @(negedge clk);
        chk("R7 flag sticky", {7'd0, reloc_err}, 8'h01);

        // R7 set wins over simultaneous clear
        bus_wr(1'b0, 8'hE7);
        @(negedge clk);
        io_addr = 1'b1; io_wdata = 8'h11; io_wr = 1'b1; reloc_err_clr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; reloc_err_clr = 1'b0;
        chk("R7 set beats clear", {7'd0, reloc_err}, 8'h01);
        read_reg(8'hE7, v);
        chk("R6 E7 moved value stored", v, 8'h11);

        // R5: closing window blocks writes of selector and data
        bus_wr(1'b0, 8'hF0);
        @(negedge clk); cfg_win_en = 1'b0;
        @(negedge clk);
        bus_wr(1'b0, 8'hE0);
        bus_wr(1'b1, 8'h77);
        bus_rd(1'b0, v, c);
        chk("R5 closed read claim", {7'd0, c}, 8'h00);
        chk("R5 closed read data", v, 8'h00);
        @(negedge clk); cfg_win_en = 1'b1;
        @(negedge clk);
        bus_rd(1'b0, v, c);
        chk("R5 selector kept while closed", v, 8'hF0);
        bus_rd(1'b1, v, c);
        chk("R5 data kept while closed", v, 8'hF0 ^ 8'h5A);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule